// File: doc/BRIEF.md
# Transponder Identification Frame Serializer

This block turns a 40-bit identifier into the 64-bit read-only frame that a contactless tag returns to its reader. It builds the frame on the fly: a run of nine ones, ten rows of four identifier bits, each row followed by its own parity bit, four column parity bits, and a closing zero. It then presents the frame one bit per bit period as a plain NRZ level, and starts the frame again straight after the last bit for as long as the block runs.

The block runs from the carrier clock. A bit period lasts 64, 32 or 16 carrier cycles. A mode input picks between the standard parity rules and the phase-shift-keyed variant, which zeroes the parity bits of the first two rows. A strobe marks the first carrier cycle of every bit, and a flag marks the first bit of each frame. A downstream line coder and the modulator consume these outputs; neither is part of this block.

Top module: `rfid_frame_serializer`

## Requirements
- R1: A frame is 64 bits, sent in this order: 9 header bits, then rows 0 to 9, then 4 column parity bits for c = 0 to 3, then the stop bit. Each row r sends data bits c = 0 to 3, taken from id_i[4r+c], followed by the row's parity bit.
- R2: Every header bit is 1 and the stop bit is 0.
- R3: With psk_mode_i = 0, each row parity bit makes its row of four data bits even. Column parity bit c makes the ten bits id_i[4r+c] (r = 0 to 9) even.
- R4: With psk_mode_i = 1, the parity bits of rows 0 and 1 are 0. Rows 2 to 9 and all column parity bits follow the even rules of R3.
- R5: The first header bit of the next frame follows the stop bit with no idle period. frame_start_o is 1 in that bit's first carrier cycle.
- R6: rate_sel_i selects the bit period: 2'b00 gives 64 carrier cycles, 2'b01 gives 32, and 2'b10 or 2'b11 give 16. bit_o holds its value for the whole period.
- R7: bit_stb_o is 1 in exactly the first carrier cycle of each bit period. frame_start_o is 1 only in the first carrier cycle of header bit 0.
- R8: id_i, psk_mode_i and rate_sel_i are captured in the last carrier cycle of the stop bit and in every reset cycle. A change at any other time has no effect on the frame in progress.
- R9: Reset is synchronous and active low (rst_n = 0). In the first cycle after release, bit_stb_o = 1, frame_start_o = 1 and bit_o = 1 (header bit 0, cycle 0), and the frame uses the inputs present in the last reset cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock |
| rst_n | input | 1 | Synchronous reset, active low |
| id_i | input | 40 | Identifier; bit 4r+c is data bit c of row r |
| psk_mode_i | input | 1 | 1 selects the phase-shift-keyed parity rules |
| rate_sel_i | input | 2 | Bit period select (64/32/16/16 carrier cycles) |
| bit_o | output | 1 | Serial NRZ frame bit |
| bit_stb_o | output | 1 | First carrier cycle of each bit period |
| frame_start_o | output | 1 | First carrier cycle of header bit 0 |

## Verification
Two functions can act in the same carrier cycle: the frame wrap from the stop bit back to the header, and the capture of a new identifier. The bench provokes the collision by changing id_i in the final carrier cycle of the stop bit. It passes if the frame that ends stays intact, the next frame starts with no gap, and that next frame carries the new identifier. A second change, made in the middle of a frame, must leave that frame untouched and take effect only at the next wrap.

// File: rtl/rfid_frame_pkg.sv
// Shared sizes, the rate encoding and the period decoder for the transponder
// frame serializer. Assumes the frame geometry used by every module below.
package rfid_frame_pkg;

    localparam int ID_W      = 40;
    localparam int NIB_W     = 4;
    localparam int ROWS      = 10;
    localparam int HDR_LEN   = 9;
    localparam int FRAME_LEN = HDR_LEN + ROWS * (NIB_W + 1) + NIB_W + 1;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam int PER_W     = 7;
    localparam int PSK_ROWS  = 2;

    typedef enum logic [1:0] {
        RATE_64  = 2'b00,
        RATE_32  = 2'b01,
        RATE_16  = 2'b10,
        RATE_16B = 2'b11
    } rate_e;

    // Carrier cycles per bit for a rate code.
    function automatic logic [PER_W-1:0] period_of(input rate_e sel);
        case (sel)
            RATE_64: period_of = PER_W'(64);
            RATE_32: period_of = PER_W'(32);
            default: period_of = PER_W'(16);
        endcase
    endfunction

endpackage

// File: rtl/rfid_bit_timer.sv
// Counts carrier cycles inside one bit period.
// Assumes: period is at least 2 and changes only when bit_last is high.
module rfid_bit_timer #(
    parameter int PER_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period,
    output logic             bit_stb,
    output logic             bit_last
);

    logic [PER_W-1:0] cnt;

    // Advance the cycle counter and wrap it at the end of each bit period.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (bit_last) cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end

    assign bit_stb  = (cnt == '0);
    assign bit_last = (cnt == period - 1'b1);

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb);                                         // R7
    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < period);                                                 // R6

endmodule

// File: rtl/rfid_bit_sequencer.sv
// Holds the index of the frame bit on the line and steps it once per bit period.
// Assumes: advance is high for one carrier cycle per bit period.
module rfid_bit_sequencer #(
    parameter int FRAME_LEN = 64,
    parameter int IDX_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] idx,
    output logic             wrap
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    assign wrap = advance && (idx == LAST_IDX);

    // Step the bit index and return to the header after the stop bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       idx <= '0;
        else if (wrap)    idx <= '0;
        else if (advance) idx <= idx + 1'b1;
    end

    AST_WRAP_TO_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (idx == '0));                                         // R5
    AST_IDX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(idx));                                    // R6

endmodule

// File: rtl/rfid_frame_builder.sv
// Forms the full frame from a captured identifier: header, rows of data with
// row parity, column parity and stop bit. Bit 0 of frame goes out first.
// Assumes: purely combinational; its inputs change only at frame boundaries.
module rfid_frame_builder #(
    parameter int ID_W      = 40,
    parameter int NIB_W     = 4,
    parameter int ROWS      = 10,
    parameter int HDR_LEN   = 9,
    parameter int FRAME_LEN = 64,
    parameter int PSK_ROWS  = 2
) (
    input  logic [ID_W-1:0]      id,
    input  logic                 psk,
    output logic [FRAME_LEN-1:0] frame
);

    localparam int ROW_LEN  = NIB_W + 1;
    localparam int COL_BASE = HDR_LEN + ROWS * ROW_LEN;

    assign frame[HDR_LEN-1:0]  = '1;
    assign frame[FRAME_LEN-1]  = 1'b0;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        localparam bit LOW_ROW = (r < PSK_ROWS);
        logic row_par;
        // Row parity: even, or forced low for the first rows in PSK mode.
        always_comb begin
            if (psk && LOW_ROW) row_par = 1'b0;
            else                row_par = ^id[r*NIB_W +: NIB_W];
        end
        assign frame[HDR_LEN + r*ROW_LEN +: NIB_W] = id[r*NIB_W +: NIB_W];
        assign frame[HDR_LEN + r*ROW_LEN + NIB_W]  = row_par;
    end

    for (genvar c = 0; c < NIB_W; c++) begin : g_col
        logic col_par;
        // Column parity: even over the same bit position of every row.
        always_comb begin
            col_par = 1'b0;
            for (int r = 0; r < ROWS; r++) col_par ^= id[r*NIB_W + c];
        end
        assign frame[COL_BASE + c] = col_par;
    end

endmodule

// File: rtl/rfid_frame_serializer.sv
// Top of the transponder frame serializer. Captures the identifier, mode and
// rate at each frame boundary, then sends the frame as an NRZ bit stream.
// Assumes: clk is the carrier; downstream logic handles line coding.
module rfid_frame_serializer
    import rfid_frame_pkg::*;
#(
    parameter int P_ID_W = ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [P_ID_W-1:0] id_i,
    input  logic              psk_mode_i,
    input  logic [1:0]        rate_sel_i,
    output logic              bit_o,
    output logic              bit_stb_o,
    output logic              frame_start_o
);

    localparam logic [IDX_W-1:0] POS_ROW0_PAR = IDX_W'(HDR_LEN + NIB_W);
    localparam logic [IDX_W-1:0] POS_ROW1_PAR = IDX_W'(HDR_LEN + 2*NIB_W + 1);
    localparam logic [IDX_W-1:0] POS_STOP     = IDX_W'(FRAME_LEN - 1);

    logic [P_ID_W-1:0]    id_q;
    logic                 psk_q;
    rate_e                rate_q;
    logic [PER_W-1:0]     period;
    logic                 bit_last;
    logic [IDX_W-1:0]     idx;
    logic                 frame_wrap;
    logic [FRAME_LEN-1:0] frame;

    // Capture the frame inputs during reset and at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_wrap) begin
            id_q   <= id_i;
            psk_q  <= psk_mode_i;
            rate_q <= rate_e'(rate_sel_i);
        end
    end

    assign period = period_of(rate_q);

    rfid_bit_timer #(.PER_W(PER_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .period   (period),
        .bit_stb  (bit_stb_o),
        .bit_last (bit_last)
    );

    rfid_bit_sequencer #(.FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (bit_last),
        .idx     (idx),
        .wrap    (frame_wrap)
    );

    rfid_frame_builder #(
        .ID_W(P_ID_W), .NIB_W(NIB_W), .ROWS(ROWS), .HDR_LEN(HDR_LEN),
        .FRAME_LEN(FRAME_LEN), .PSK_ROWS(PSK_ROWS)
    ) builder_i (
        .id    (id_q),
        .psk   (psk_q),
        .frame (frame)
    );

    assign bit_o         = frame[idx];
    assign frame_start_o = bit_stb_o && (idx == '0);

    AST_HEADER_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (idx < IDX_W'(HDR_LEN)) |-> bit_o);                            // R2
    AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == POS_STOP) |-> !bit_o);                                 // R2
    AST_PSK_LOW_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (psk_q && (idx == POS_ROW0_PAR || idx == POS_ROW1_PAR)) |-> !bit_o); // R4
    AST_BIT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb_o |-> $stable(bit_o));                                // R6
    AST_ID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_wrap |=> $stable(id_q));                                // R8

endmodule

// File: tb/rfid_frame_serializer_tb_top.sv
// Directed bench for the frame serializer: each task runs one scenario and
// checks its own results against a frame model derived from the requirements.
module rfid_frame_serializer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] id_i = '0;
    logic        psk_mode_i = 1'b0;
    logic [1:0]  rate_sel_i = 2'b00;
    logic        bit_o, bit_stb_o, frame_start_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    rfid_frame_serializer dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .id_i          (id_i),
        .psk_mode_i    (psk_mode_i),
        .rate_sel_i    (rate_sel_i),
        .bit_o         (bit_o),
        .bit_stb_o     (bit_stb_o),
        .frame_start_o (frame_start_o)
    );

    // Expected frame, index 0 sent first (R1..R4).
    function automatic logic [63:0] ref_frame(input logic [39:0] id, input logic psk);
        logic [63:0] f;
        f = '0;
        for (int i = 0; i < 9; i++) f[i] = 1'b1;
        for (int r = 0; r < 10; r++) begin
            logic p;
            p = 1'b0;
            for (int c = 0; c < 4; c++) begin
                f[9 + 5*r + c] = id[4*r + c];
                p = p ^ id[4*r + c];
            end
            if (psk && r < 2) p = 1'b0;
            f[9 + 5*r + 4] = p;
        end
        for (int c = 0; c < 4; c++) begin
            logic q;
            q = 1'b0;
            for (int r = 0; r < 10; r++) q = q ^ id[4*r + c];
            f[59 + c] = q;
        end
        f[63] = 1'b0;
        return f;
    endfunction

    function automatic int per_of(input logic [1:0] sel);
        case (sel)
            2'b00:   return 64;
            2'b01:   return 32;
            default: return 16;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // Load new inputs, then stop at the first frame start that uses them.
    task automatic set_and_align(input logic [39:0] id, input logic psk, input logic [1:0] rs);
        id_i = id;
        psk_mode_i = psk;
        rate_sel_i = rs;
        @(negedge clk);
        while (!frame_start_o) @(negedge clk);
    endtask

    // Record one frame from its first strobe; optionally change id_i at bit chg_bit, cycle chg_off.
    task automatic capture(input logic [63:0] exp, input int per, input int chg_bit,
                           input int chg_off, input logic [39:0] chg_id, input string tag);
        logic [63:0] got;
        int bad_gap = 0;
        int bad_fs  = 0;
        got = '0;
        for (int k = 0; k < 64; k++) begin
            got[k] = bit_o;
            if (bit_stb_o !== 1'b1) bad_gap++;
            if ((k == 0) != (frame_start_o === 1'b1)) bad_fs++;
            for (int off = 1; off < per; off++) begin
                @(negedge clk);
                if (k == chg_bit && off == chg_off) id_i = chg_id;
                if (bit_stb_o !== 1'b0 || bit_o !== got[k]) bad_gap++;
            end
            @(negedge clk);
        end
        check(got === exp, "R1/R2/R3/R4", {tag, " frame content"}, got, exp);
        check(bad_gap == 0, "R6", {tag, " bit period length and steady level"}, 64'(bad_gap), 64'd0);
        check(bad_fs == 0, "R7", {tag, " strobe and frame start placement"}, 64'(bad_fs), 64'd0);
        check(frame_start_o === 1'b1 && bit_stb_o === 1'b1, "R5",
              {tag, " next frame follows with no gap"}, 64'(frame_start_o), 64'd1);
    endtask

    // R9: state after reset and first frame from inputs held during reset.
    task automatic t_reset_start();
        logic [39:0] a;
        a = 40'h12_3456_789A;
        id_i = a; psk_mode_i = 1'b0; rate_sel_i = 2'b01;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(bit_stb_o === 1'b1 && frame_start_o === 1'b1 && bit_o === 1'b1, "R9",
              "outputs after reset release", {61'd0, bit_stb_o, frame_start_o, bit_o}, 64'd7);
        capture(ref_frame(a, 1'b0), 32, -1, 0, '0, "reset-start");
    endtask

    // R3/R6: standard parity at the slowest rate.
    task automatic t_std_64();
        logic [39:0] b;
        b = 40'hA5_C3F0_1E69;
        set_and_align(b, 1'b0, 2'b00);
        capture(ref_frame(b, 1'b0), 64, -1, 0, '0, "std-64");
    endtask

    // R4: PSK rule where rows 0 and 1 have odd weight, so even parity would be 1.
    task automatic t_psk_16();
        logic [39:0] c;
        c = 40'h5E_D2B4_C917;
        set_and_align(c, 1'b1, 2'b10);
        capture(ref_frame(c, 1'b1), 16, -1, 0, '0, "psk-16");
    endtask

    // R6: code 2'b11 also gives 16 cycles; all-ones identifier.
    task automatic t_rate_alias();
        set_and_align('1, 1'b0, 2'b11);
        capture(ref_frame('1, 1'b0), 16, -1, 0, '0, "ones-rate11");
    endtask

    // R3/R4: all-zero identifier in PSK mode at 32 cycles per bit.
    task automatic t_zero_psk();
        set_and_align('0, 1'b1, 2'b01);
        capture(ref_frame('0, 1'b1), 32, -1, 0, '0, "zero-psk");
    endtask

    // R8/R5: mid-frame change ignored; change in the wrap cycle taken by the next frame.
    task automatic t_sampling();
        logic [39:0] e, f, g;
        e = 40'h0F_1E2D_3C4B;
        f = 40'hFE_DCBA_9876;
        g = 40'h01_2345_6789;
        set_and_align(e, 1'b0, 2'b10);
        capture(ref_frame(e, 1'b0), 16, 20, 5, f, "R8 mid-frame change");
        capture(ref_frame(f, 1'b0), 16, 63, 15, g, "R8 change in wrap cycle");
        capture(ref_frame(g, 1'b0), 16, -1, 0, '0, "R8 after wrap change");
    endtask

    // R9: reset in the middle of a frame restarts at the header with new inputs.
    task automatic t_reset_mid();
        logic [39:0] d;
        d = 40'h33_CC55_AA93;
        set_and_align(40'hFF_0000_FFFF, 1'b0, 2'b00);
        repeat (700) @(negedge clk);
        id_i = d; psk_mode_i = 1'b1; rate_sel_i = 2'b10;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(bit_stb_o === 1'b1 && frame_start_o === 1'b1 && bit_o === 1'b1, "R9",
              "outputs after mid-frame reset", {61'd0, bit_stb_o, frame_start_o, bit_o}, 64'd7);
        capture(ref_frame(d, 1'b1), 16, -1, 0, '0, "R9 reset-mid");
    endtask

    initial begin
        t_reset_start();
        t_std_64();
        t_psk_16();
        t_rate_alias();
        t_zero_psk();
        t_sampling();
        t_reset_mid();
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule